// File: doc/BRIEF.md
# Wait-Bit Issue Scheduler

This block is an issue queue whose readiness logic knows about long-latency load misses. Each physical register carries three pieces of state: a truly-ready flag, a waiting flag, and the index of the miss vector that the waiting value hangs on. An instruction whose sources are all truly ready issues normally to execution. An instruction with at least one waiting source, and every other source truly ready, is pretend ready. It competes for issue in the same way, but on selection it is sent to the waiting buffer, not to a functional unit. Its queue slot is freed either way. The miss-vector index travels with the evicted instruction and is copied onto its destination register. Consumers of that register are then evicted in turn, so the whole dependence chain of a missed load leaves the queue.

A single insertion slot per cycle is shared by reinsertion from the waiting buffer and new dispatch, and reinsertion wins. Queue entries hold only register numbers. Readiness is therefore read live from the register table, and an instruction whose producers have already left the queue still sees the correct state. A miss-done event turns every register tagged with that vector truly ready. A flush removes all entries at or younger than a given age.

Top module: `wait_sched`

## Requirements
- R1: After reset every physical register is truly ready and not waiting, the queue is empty, `iss_valid` is 0, and both `in_ready` and `ri_ready` are 1.
- R2: A newly dispatched instruction clears the ready and waiting state of its destination register. An instruction reading a register that is neither ready nor waiting does not issue until `wb_valid` for that register makes it ready.
- R3: An instruction whose two sources are truly ready issues with `iss_to_wib` = 0 and its own `iss_dst` and `iss_age`.
- R4: `miss_valid` marks `miss_preg` as waiting with tag `miss_vec`. An instruction with one waiting source and the other truly ready issues with `iss_to_wib` = 1 and `iss_vec` equal to that tag.
- R5: An instruction with one waiting source and one source that is neither ready nor waiting does not issue.
- R6: An instruction issued with `iss_to_wib` = 1 leaves its destination register waiting, tagged with `iss_vec`, so its consumers are also sent to the waiting buffer with the same tag.
- R7: When both sources are waiting on different vectors, `iss_vec` is the tag of source 0.
- R8: `done_valid` makes every register that is waiting with tag `done_vec` truly ready. Registers waiting on other tags stay waiting.
- R9: When several entries request issue, the one with the smallest age (oldest) is issued first, one per cycle.
- R10: When `ri_valid` and `in_valid` are both high and the queue has room, the reinserted instruction is taken, `in_ready` is 0, and the dispatched one is not written.
- R11: With all queue entries occupied, `in_ready` and `ri_ready` are 0.
- R12: `flush_valid` removes every entry whose age is greater than or equal to `flush_age`, keeps older entries, and suppresses issue in that cycle.
- R13: Each queued instruction issues exactly once, and its slot is freed on issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New dispatch request |
| in_src0 | input | PR_W | Dispatch source register 0 |
| in_src1 | input | PR_W | Dispatch source register 1 |
| in_dst | input | PR_W | Dispatch destination register |
| in_age | input | AGE_W | Dispatch age (larger is younger) |
| in_ready | output | 1 | Dispatch accepted this cycle |
| ri_valid | input | 1 | Reinsertion request from waiting buffer |
| ri_src0 | input | PR_W | Reinsert source register 0 |
| ri_src1 | input | PR_W | Reinsert source register 1 |
| ri_dst | input | PR_W | Reinsert destination register |
| ri_age | input | AGE_W | Reinsert age |
| ri_ready | output | 1 | Reinsertion accepted this cycle |
| wb_valid | input | 1 | Producer result written back |
| wb_preg | input | PR_W | Register written back |
| miss_valid | input | 1 | Load miss detected |
| miss_preg | input | PR_W | Destination register of the missed load |
| miss_vec | input | VEC_W | Miss vector index given to the load |
| done_valid | input | 1 | A miss has completed |
| done_vec | input | VEC_W | Vector index of the completed miss |
| flush_valid | input | 1 | Squash request |
| flush_age | input | AGE_W | Oldest age removed by the squash |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_to_wib | output | 1 | 1: to waiting buffer, 0: to execution |
| iss_dst | output | PR_W | Destination of the issued instruction |
| iss_age | output | AGE_W | Age of the issued instruction |
| iss_vec | output | VEC_W | Miss vector carried to the waiting buffer |

## Verification
The assertions take for granted that ages in the queue are unique. They also assume a register is not given a miss, a wait propagation and a completion of the same vector in one cycle. The stimulus allocates a fresh age for every instruction. It drives miss, writeback, completion and flush events only in cycles where no conflicting update hits the same register. Each expected issue is queued by the driver in age order, and any extra or missing issue shows up as a mismatch.

// File: rtl/wait_sched.sv
module wait_sched #(
  parameter int NQ    = 8,
  parameter int NPR   = 16,
  parameter int NVEC  = 4,
  parameter int AGE_W = 8,
  localparam int PR_W  = $clog2(NPR),
  localparam int VEC_W = $clog2(NVEC),
  localparam int Q_W   = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PR_W-1:0]  in_src0,
  input  logic [PR_W-1:0]  in_src1,
  input  logic [PR_W-1:0]  in_dst,
  input  logic [AGE_W-1:0] in_age,
  output logic             in_ready,
  input  logic             ri_valid,
  input  logic [PR_W-1:0]  ri_src0,
  input  logic [PR_W-1:0]  ri_src1,
  input  logic [PR_W-1:0]  ri_dst,
  input  logic [AGE_W-1:0] ri_age,
  output logic             ri_ready,
  input  logic             wb_valid,
  input  logic [PR_W-1:0]  wb_preg,
  input  logic             miss_valid,
  input  logic [PR_W-1:0]  miss_preg,
  input  logic [VEC_W-1:0] miss_vec,
  input  logic             done_valid,
  input  logic [VEC_W-1:0] done_vec,
  input  logic             flush_valid,
  input  logic [AGE_W-1:0] flush_age,
  output logic             iss_valid,
  output logic             iss_to_wib,
  output logic [PR_W-1:0]  iss_dst,
  output logic [AGE_W-1:0] iss_age,
  output logic [VEC_W-1:0] iss_vec
);
  logic [NQ-1:0]    q_v;
  logic [PR_W-1:0]  q_s0  [NQ];
  logic [PR_W-1:0]  q_s1  [NQ];
  logic [PR_W-1:0]  q_dst [NQ];
  logic [AGE_W-1:0] q_age [NQ];

  logic [NPR-1:0]   r_rdy, r_wt;
  logic [VEC_W-1:0] r_vec [NPR];

  logic [NQ-1:0]    req, pre;
  logic [VEC_W-1:0] e_vec [NQ];

  for (genvar i = 0; i < NQ; i++) begin : g_eval
    assign req[i]   = q_v[i] && (r_rdy[q_s0[i]] || r_wt[q_s0[i]])
                             && (r_rdy[q_s1[i]] || r_wt[q_s1[i]]);
    assign pre[i]   = r_wt[q_s0[i]] || r_wt[q_s1[i]];
    assign e_vec[i] = r_wt[q_s0[i]] ? r_vec[q_s0[i]] : r_vec[q_s1[i]];
  end

  logic             found;
  logic [Q_W-1:0]   sel;
  logic [AGE_W-1:0] best;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int i = 0; i < NQ; i++) begin
      if (req[i] && (!found || q_age[i] < best)) begin
        found = 1'b1;
        sel   = Q_W'(i);
        best  = q_age[i];
      end
    end
  end

  assign iss_valid  = found && !flush_valid;
  assign iss_to_wib = pre[sel];
  assign iss_dst    = q_dst[sel];
  assign iss_age    = q_age[sel];
  assign iss_vec    = pre[sel] ? e_vec[sel] : '0;

  logic           full;
  logic [Q_W-1:0] slot;
  always_comb begin
    slot = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (!q_v[i]) slot = Q_W'(i);
  end
  assign full     = &q_v;
  assign ri_ready = !full;
  assign in_ready = !full && !ri_valid;

  logic [PR_W-1:0]  ins_s0, ins_s1, ins_dst;
  logic [AGE_W-1:0] ins_age;
  logic             ins_take, ins_fire, ins_new;
  assign ins_s0   = ri_valid ? ri_src0 : in_src0;
  assign ins_s1   = ri_valid ? ri_src1 : in_src1;
  assign ins_dst  = ri_valid ? ri_dst  : in_dst;
  assign ins_age  = ri_valid ? ri_age  : in_age;
  assign ins_take = ri_valid ? ri_ready : (in_valid && in_ready);
  assign ins_new  = !ri_valid;
  assign ins_fire = ins_take && !(flush_valid && ins_age >= flush_age);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= '0;
      for (int i = 0; i < NQ; i++) begin
        q_s0[i]  <= '0;
        q_s1[i]  <= '0;
        q_dst[i] <= '0;
        q_age[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (flush_valid && q_age[i] >= flush_age) q_v[i] <= 1'b0;
        if (iss_valid && sel == Q_W'(i)) q_v[i] <= 1'b0;
      end
      if (ins_fire) begin
        q_v[slot]   <= 1'b1;
        q_s0[slot]  <= ins_s0;
        q_s1[slot]  <= ins_s1;
        q_dst[slot] <= ins_dst;
        q_age[slot] <= ins_age;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_rdy <= '1;
      r_wt  <= '0;
      for (int r = 0; r < NPR; r++) r_vec[r] <= '0;
    end else begin
      for (int r = 0; r < NPR; r++)
        if (done_valid && r_wt[r] && r_vec[r] == done_vec) begin
          r_rdy[r] <= 1'b1;
          r_wt[r]  <= 1'b0;
        end
      if (wb_valid) begin
        r_rdy[wb_preg] <= 1'b1;
        r_wt[wb_preg]  <= 1'b0;
      end
      if (ins_fire && ins_new) begin
        r_rdy[ins_dst] <= 1'b0;
        r_wt[ins_dst]  <= 1'b0;
      end
      if (iss_valid && iss_to_wib) begin
        r_rdy[iss_dst] <= 1'b0;
        r_wt[iss_dst]  <= 1'b1;
        r_vec[iss_dst] <= iss_vec;
      end
      if (miss_valid) begin
        r_rdy[miss_preg] <= 1'b0;
        r_wt[miss_preg]  <= 1'b1;
        r_vec[miss_preg] <= miss_vec;
      end
    end
  end
endmodule

// File: rtl/wait_sched_chk.sv
module wait_sched_chk #(
  parameter int NQ    = 8,
  parameter int NPR   = 16,
  parameter int PR_W  = 4,
  parameter int VEC_W = 2,
  parameter int AGE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PR_W-1:0]  in_dst,
  input logic             in_ready,
  input logic             ri_valid,
  input logic             ri_ready,
  input logic             miss_valid,
  input logic [PR_W-1:0]  miss_preg,
  input logic             flush_valid,
  input logic             iss_valid,
  input logic             iss_to_wib,
  input logic [PR_W-1:0]  iss_dst,
  input logic [AGE_W-1:0] iss_age,
  input logic [VEC_W-1:0] iss_vec,
  input logic [NQ-1:0]    q_v,
  input logic [NPR-1:0]   r_wt,
  input logic [VEC_W-1:0] r_vec [NPR]
);
  AST_REINSERT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_valid && in_valid && ri_ready) |-> !in_ready); // R10
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(q_v) == NQ) |-> (!ri_ready && !in_ready)); // R11
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !iss_valid); // R12
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_age == $past(iss_age))); // R13
  AST_WAIT_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_to_wib && !(miss_valid && miss_preg == iss_dst)
     && !(in_valid && in_ready && in_dst == iss_dst))
    |=> (r_wt[$past(iss_dst)] && r_vec[$past(iss_dst)] == $past(iss_vec))); // R6
endmodule

bind wait_sched wait_sched_chk #(
  .NQ(NQ), .NPR(NPR), .PR_W(PR_W), .VEC_W(VEC_W), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
  .in_ready(in_ready), .ri_valid(ri_valid), .ri_ready(ri_ready),
  .miss_valid(miss_valid), .miss_preg(miss_preg), .flush_valid(flush_valid),
  .iss_valid(iss_valid), .iss_to_wib(iss_to_wib), .iss_dst(iss_dst),
  .iss_age(iss_age), .iss_vec(iss_vec), .q_v(q_v), .r_wt(r_wt), .r_vec(r_vec)
);

// File: tb/wait_sched_tb.sv
module wait_sched_tb;
  localparam int PR_W = 4, VEC_W = 2, AGE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 0, ri_valid = 0, wb_valid = 0, miss_valid = 0, done_valid = 0, flush_valid = 0;
  logic [PR_W-1:0] in_src0 = 0, in_src1 = 0, in_dst = 0, ri_src0 = 0, ri_src1 = 0, ri_dst = 0;
  logic [PR_W-1:0] wb_preg = 0, miss_preg = 0;
  logic [AGE_W-1:0] in_age = 0, ri_age = 0, flush_age = 0;
  logic [VEC_W-1:0] miss_vec = 0, done_vec = 0;
  logic in_ready, ri_ready, iss_valid, iss_to_wib;
  logic [PR_W-1:0] iss_dst;
  logic [AGE_W-1:0] iss_age;
  logic [VEC_W-1:0] iss_vec;

  wait_sched u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [PR_W+1+VEC_W+AGE_W-1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_iss(input int d, input bit w, input int v, input int a, input string tag);
    exp_q.push_back({PR_W'(d), w, VEC_W'(v), AGE_W'(a)});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && iss_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R13 unexpected issue", int'(iss_age), -1);
      end else begin
        logic [PR_W+1+VEC_W+AGE_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({iss_dst, iss_to_wib, (iss_to_wib ? iss_vec : e[AGE_W +: VEC_W]), iss_age} == e,
            t, int'({iss_dst, iss_to_wib, iss_vec, iss_age}), int'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic dispatch(input int s0, input int s1, input int d, input int a);
    in_valid = 1; in_src0 = PR_W'(s0); in_src1 = PR_W'(s1); in_dst = PR_W'(d); in_age = AGE_W'(a);
    step();
    in_valid = 0;
  endtask

  task automatic wb(input int p);
    wb_valid = 1; wb_preg = PR_W'(p); step(); wb_valid = 0;
  endtask

  task automatic miss(input int p, input int v);
    miss_valid = 1; miss_preg = PR_W'(p); miss_vec = VEC_W'(v); step(); miss_valid = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 50) begin step(); n++; end
    if (exp_q.size() != 0) begin
      chk(0, {tag, " missing issue"}, 0, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    step();
  endtask

  task automatic quiet(input string tag);
    repeat (3) step();
    @(negedge clk);
    chk(iss_valid == 0, tag, iss_valid, 0);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(iss_valid == 0 && in_ready && ri_ready, "R1 reset state", {iss_valid, in_ready, ri_ready}, 3);
    step();

    expect_iss(2, 0, 0, 10, "R3 ready issue");
    dispatch(0, 1, 2, 10);
    drain("R3");
    dispatch(2, 0, 3, 11);
    quiet("R2 blocked on unready source");
    expect_iss(3, 0, 0, 11, "R2 issue after writeback");
    wb(2);
    drain("R2");

    miss(4, 1);
    expect_iss(5, 1, 1, 12, "R4 pretend ready to buffer");
    dispatch(4, 0, 5, 12);
    drain("R4");
    expect_iss(6, 1, 1, 13, "R6 chain evicted");
    dispatch(0, 5, 6, 13);
    drain("R6");

    expect_iss(7, 0, 0, 14, "R3 producer");
    dispatch(0, 0, 7, 14);
    drain("R3");
    dispatch(4, 7, 8, 15);
    quiet("R5 waiting plus unready stays");
    expect_iss(8, 1, 1, 15, "R5 leaves after writeback");
    wb(7);
    drain("R5");

    miss(9, 2);
    miss(10, 3);
    expect_iss(11, 1, 2, 16, "R7 src0 vector first");
    expect_iss(12, 1, 3, 17, "R7 src0 vector swapped");
    dispatch(9, 10, 11, 16);
    dispatch(10, 9, 12, 17);
    drain("R7");

    done_valid = 1; done_vec = 1; step(); done_valid = 0;
    expect_iss(13, 0, 0, 18, "R8 completed vector ready");
    expect_iss(14, 1, 2, 19, "R8 other vector still waiting");
    dispatch(4, 8, 13, 18);
    dispatch(9, 0, 14, 19);
    drain("R8");

    expect_iss(15, 0, 0, 20, "R3 producer");
    dispatch(0, 0, 15, 20);
    drain("R3");
    dispatch(15, 0, 1, 30);
    dispatch(15, 0, 2, 25);
    dispatch(15, 0, 3, 28);
    expect_iss(2, 0, 0, 25, "R9 oldest first");
    expect_iss(3, 0, 0, 28, "R9 second oldest");
    expect_iss(1, 0, 0, 30, "R9 youngest last");
    wb(15);
    drain("R9");
    quiet("R13 no reissue");

    expect_iss(15, 0, 0, 31, "R3 producer");
    dispatch(0, 0, 15, 31);
    drain("R3");
    in_valid = 1; in_src0 = 15; in_src1 = 0; in_dst = 1; in_age = 40;
    ri_valid = 1; ri_src0 = 15; ri_src1 = 0; ri_dst = 2; ri_age = 41;
    @(negedge clk);
    chk(!in_ready && ri_ready, "R10 reinsert priority", {in_ready, ri_ready}, 1);
    step();
    in_valid = 0; ri_valid = 0;
    expect_iss(2, 0, 0, 41, "R10 only reinserted entry");
    wb(15);
    drain("R10");

    expect_iss(15, 0, 0, 42, "R3 producer");
    dispatch(0, 0, 15, 42);
    drain("R3");
    for (int k = 0; k < 8; k++) dispatch(15, 0, 1, 50 + k);
    @(negedge clk);
    chk(!in_ready && !ri_ready, "R11 full", {in_ready, ri_ready}, 0);
    step();
    flush_valid = 1; flush_age = 54; step(); flush_valid = 0;
    @(negedge clk);
    chk(in_ready == 1, "R12 flush frees younger", in_ready, 1);
    step();
    for (int k = 0; k < 4; k++) expect_iss(1, 0, 0, 50 + k, "R12 older entries kept");
    wb(15);
    drain("R12");

    dispatch(0, 0, 3, 60);
    flush_valid = 1; flush_age = 70;
    @(negedge clk);
    chk(iss_valid == 0, "R12 no issue during flush", iss_valid, 0);
    step();
    flush_valid = 0;
    expect_iss(3, 0, 0, 60, "R12 older entry survives flush");
    drain("R12");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule